// File: doc/BRIEF.md
# Multi-Cycle Load/Store Processor Datapath

This block is the 32-bit datapath of a small load/store processor. Each instruction runs over several clock cycles: fetch, decode, execute, memory and write-back. A set of step registers carries values from one cycle to the next. These are the instruction register, two operand registers, an ALU result register and a memory data register. The block holds the program counter, a 32-entry register file, immediate extension, the branch target adder and a five-function ALU. It also holds a separate instruction memory and data memory, both modelled as internal word arrays that a testbench can preload.

The datapath takes no decisions of its own. An external controller drives every register enable and multiplexer select, one cycle at a time. The datapath returns the opcode and function fields of the held instruction and the ALU zero flag. The program counter moves only when the controller asserts its write enable, normally in the last cycle of an instruction. It then takes either PC+4 or the branch target.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_n` is low at a clock edge, the program counter, instruction register, both operand registers, the ALU result register, the memory data register and all register-file entries clear to zero.
- R2: The held instruction is split at fixed positions: `opcode_o` = bits 31:26, source register index = bits 25:21, target register index = bits 20:16, destination register index = bits 15:11, immediate = bits 15:0, `funct_o` = bits 5:0.
- R3: When `ir_wr` is high, the instruction register loads the instruction-memory word at word index PC[7:2] (byte address divided by four). When `ir_wr` is low, it holds its value.
- R4: When `a_wr` is high, operand A loads the register selected by bits 25:21. When `b_wr` is high, operand B loads the register selected by bits 20:16. Each holds its value while its enable is low.
- R5: The ALU function is set by `alu_ctrl`: 000 AND, 001 OR, 010 add, 110 subtract (A minus second operand), 111 signed set-less-than (result 1 or 0). Any other code gives 0. When `r_wr` is high, the ALU result register captures the result.
- R6: With `alu_src_b` high, the second ALU operand is the immediate, zero-extended when `ext_zero` is high and sign-extended when it is low. With `alu_src_b` low, the second operand is B.
- R7: `zero_o` is high exactly when the current combinational ALU result is all zeros.
- R8: When `pc_wr` is high, the PC loads PC+4 if `pc_src` is 0, or PC+4 plus the sign-extended immediate shifted left by two if `pc_src` is 1. When `pc_wr` is low, the PC holds its value.
- R9: When `reg_wr` is high, the register file writes to the destination index (bits 15:11) if `reg_dst` is 1, or to the target index (bits 20:16) if it is 0. The data written is the memory data register if `mem_to_reg` is 1, or the ALU result register if it is 0.
- R10: Register 0 always reads as zero, and a write to it has no effect.
- R11: When `m_wr` is high, the memory data register captures the data-memory word at word index R[7:2], where R is the ALU result register. When `mem_wr` is high, operand B is written to that same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_wr | input | 1 | Program counter write enable |
| pc_src | input | 1 | PC source: 0 = PC+4, 1 = branch target |
| ir_wr | input | 1 | Instruction register load enable |
| a_wr | input | 1 | Operand A load enable |
| b_wr | input | 1 | Operand B load enable |
| alu_src_b | input | 1 | Second ALU operand: 0 = B, 1 = extended immediate |
| ext_zero | input | 1 | Immediate extension: 1 = zero-extend, 0 = sign-extend |
| alu_ctrl | input | 3 | ALU function code |
| r_wr | input | 1 | ALU result register load enable |
| m_wr | input | 1 | Memory data register load enable |
| mem_wr | input | 1 | Data memory write enable |
| reg_wr | input | 1 | Register file write enable |
| reg_dst | input | 1 | Write index: 1 = bits 15:11, 0 = bits 20:16 |
| mem_to_reg | input | 1 | Write data: 1 = memory data register, 0 = ALU result register |
| opcode_o | output | 6 | Instruction bits 31:26 |
| funct_o | output | 6 | Instruction bits 5:0 |
| zero_o | output | 1 | Combinational ALU result is zero |
| pc_o | output | 32 | Program counter |
| alu_res_o | output | 32 | ALU result register |
| mdr_o | output | 32 | Memory data register |

## Verification
The bound assertions are checked on every clock. They cover the state after reset, the hold of the PC, the instruction fields and the memory data register when their enables are low, and the PC+4 step. They also check that the ALU result register captures the ALU output and that operand A reads zero from register 0. Only the bench scenarios can show the rest. These are the values computed for each ALU function, zero versus sign extension, the branch target taken and not taken, the choice of write index and write data, and a store followed by a load of the same word. In those scenarios a behavioural model is compared with the block on every cycle.

// File: rtl/mcd_pkg.sv
// Shared constants and types for the multi-cycle datapath.
// Assumes a fixed 32-bit word and a 32-entry register file.
package mcd_pkg;
    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_fn_e;

    typedef struct packed {
        logic [5:0]        op;
        logic [RIDX_W-1:0] src;
        logic [RIDX_W-1:0] tgt;
        logic [RIDX_W-1:0] dst;
        logic [4:0]        sh;
        logic [5:0]        fn;
    } instr_t;
endpackage

// File: rtl/mcd_mem.sv
// Word-addressed memory array with a combinational read port and a
// synchronous write port. Assumes the caller passes a word index.
// The array has no reset; a testbench preloads it hierarchically.
module mcd_mem #(
    parameter int WORDS = 64,
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [WORDS];

    // Write one word on the clock edge when enabled.
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    // Read the addressed word without delay.
    assign rdata = mem[idx];
endmodule

// File: rtl/mcd_regfile.sv
// Register file with two combinational read ports and one synchronous
// write port. Entry 0 is hard-wired to zero. All entries clear on reset.
module mcd_regfile #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [WIDTH-1:0] ra_data,
    output logic [WIDTH-1:0] rb_data,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [WIDTH-1:0] w_data
);
    logic [WIDTH-1:0] regs [DEPTH];

    // Clear on reset; otherwise write the selected entry, never entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we && (w_idx != '0)) begin
            regs[w_idx] <= w_data;
        end
    end

    // Read ports force entry 0 to zero.
    assign ra_data = (ra_idx == '0) ? '0 : regs[ra_idx];
    assign rb_data = (rb_idx == '0) ? '0 : regs[rb_idx];
endmodule

// File: rtl/mcd_alu.sv
// Five-function ALU with a zero flag. Assumes signed compare for
// set-less-than; unknown function codes give zero.
module mcd_alu
    import mcd_pkg::*;
#(
    parameter int WIDTH = XLEN
) (
    input  logic [2:0]       fn,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             zero
);
    // Select the result for the requested function.
    always_comb begin
        case (fn)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/mc_datapath.sv
// Multi-cycle datapath: PC, step registers, register file, ALU,
// immediate extension, branch target and split memories. Every
// enable and select is driven by an external controller.
// Assumes word-aligned addresses; the low two address bits are ignored.
module mc_datapath
    import mcd_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int RF_DEPTH   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pc_wr,
    input  logic            pc_src,
    input  logic            ir_wr,
    input  logic            a_wr,
    input  logic            b_wr,
    input  logic            alu_src_b,
    input  logic            ext_zero,
    input  logic [2:0]      alu_ctrl,
    input  logic            r_wr,
    input  logic            m_wr,
    input  logic            mem_wr,
    input  logic            reg_wr,
    input  logic            reg_dst,
    input  logic            mem_to_reg,
    output logic [5:0]      opcode_o,
    output logic [5:0]      funct_o,
    output logic            zero_o,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] alu_res_o,
    output logic [XLEN-1:0] mdr_o
);
    localparam int IM_IDX_W = $clog2(IMEM_WORDS);
    localparam int DM_IDX_W = $clog2(DMEM_WORDS);
    localparam int IMM_W    = 16;

    logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, r_q, m_q;
    instr_t          fld;
    logic [IMM_W-1:0] imm;
    logic [XLEN-1:0] imm_sx, imm_ext, alu_b, alu_y;
    logic [XLEN-1:0] pc_plus4, br_tgt;
    logic [XLEN-1:0] im_rdata, dm_rdata, ra_data, rb_data;
    logic [RIDX_W-1:0] w_idx;
    logic [XLEN-1:0] w_data;
    logic            alu_zero;
    logic [RIDX_W-1:0] rs_idx;

    // Field split of the held instruction.
    assign fld    = instr_t'(ir_q);
    assign imm    = ir_q[IMM_W-1:0];
    assign rs_idx = fld.src;

    // Immediate extension and second-operand select.
    assign imm_sx  = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    assign imm_ext = ext_zero ? {{(XLEN-IMM_W){1'b0}}, imm} : imm_sx;
    assign alu_b   = alu_src_b ? imm_ext : b_q;

    // Next-PC candidates.
    assign pc_plus4 = pc_q + 32'd4;
    assign br_tgt   = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};

    // Register-file write port selects.
    assign w_idx  = reg_dst ? fld.dst : fld.tgt;
    assign w_data = mem_to_reg ? m_q : r_q;

    mcd_mem #(.WORDS(IMEM_WORDS), .WIDTH(XLEN)) u_imem (
        .clk   (clk),
        .we    (1'b0),
        .idx   (pc_q[IM_IDX_W+1:2]),
        .wdata ('0),
        .rdata (im_rdata)
    );

    mcd_mem #(.WORDS(DMEM_WORDS), .WIDTH(XLEN)) u_dmem (
        .clk   (clk),
        .we    (mem_wr),
        .idx   (r_q[DM_IDX_W+1:2]),
        .wdata (b_q),
        .rdata (dm_rdata)
    );

    mcd_regfile #(.DEPTH(RF_DEPTH), .WIDTH(XLEN)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (fld.src),
        .rb_idx  (fld.tgt),
        .ra_data (ra_data),
        .rb_data (rb_data),
        .we      (reg_wr),
        .w_idx   (w_idx),
        .w_data  (w_data)
    );

    mcd_alu #(.WIDTH(XLEN)) u_alu (
        .fn   (alu_ctrl),
        .a    (a_q),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Program counter: cleared on reset, updated only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= '0;
        else if (pc_wr) pc_q <= pc_src ? br_tgt : pc_plus4;
    end

    // Step registers: each loads only under its own enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
            a_q  <= '0;
            b_q  <= '0;
            r_q  <= '0;
            m_q  <= '0;
        end else begin
            if (ir_wr) ir_q <= im_rdata;
            if (a_wr)  a_q  <= ra_data;
            if (b_wr)  b_q  <= rb_data;
            if (r_wr)  r_q  <= alu_y;
            if (m_wr)  m_q  <= dm_rdata;
        end
    end

    assign opcode_o  = fld.op;
    assign funct_o   = fld.fn;
    assign zero_o    = alu_zero;
    assign pc_o      = pc_q;
    assign alu_res_o = r_q;
    assign mdr_o     = m_q;

    // Address bits outside the memory index are deliberately unused.
    logic unused_addr_bits;
    assign unused_addr_bits = ^{pc_q[1:0], pc_q[XLEN-1:IM_IDX_W+2],
                                r_q[1:0], r_q[XLEN-1:DM_IDX_W+2], fld.sh};
endmodule

// File: rtl/mcd_checker.sv
// Cycle-level properties of the datapath, bound to the top module.
module mcd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        pc_wr,
    input logic        pc_src,
    input logic        ir_wr,
    input logic        a_wr,
    input logic        r_wr,
    input logic        m_wr,
    input logic [5:0]  opcode_o,
    input logic [5:0]  funct_o,
    input logic [31:0] pc_o,
    input logic [31:0] alu_res_o,
    input logic [31:0] mdr_o,
    input logic [31:0] alu_y,
    input logic [31:0] a_q,
    input logic [4:0]  rs_idx
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pc_o == '0 && alu_res_o == '0 && mdr_o == '0 && a_q == '0));

    // R8
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_wr |=> $stable(pc_o));

    // R8
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr && !pc_src) |=> (pc_o == $past(pc_o) + 32'd4));

    // R3
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_wr |=> $stable({opcode_o, funct_o}));

    // R11
    mdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !m_wr |=> $stable(mdr_o));

    // R5
    alu_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_wr |=> (alu_res_o == $past(alu_y)));

    // R10
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && rs_idx == 5'd0) |=> (a_q == '0));
endmodule

bind mc_datapath mcd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_wr     (pc_wr),
    .pc_src    (pc_src),
    .ir_wr     (ir_wr),
    .a_wr      (a_wr),
    .r_wr      (r_wr),
    .m_wr      (m_wr),
    .opcode_o  (opcode_o),
    .funct_o   (funct_o),
    .pc_o      (pc_o),
    .alu_res_o (alu_res_o),
    .mdr_o     (mdr_o),
    .alu_y     (alu_y),
    .a_q       (a_q),
    .rs_idx    (rs_idx)
);

// File: tb/sim_mc_datapath.sv
module sim_mc_datapath;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 64;
    localparam logic [5:0] OP_RT = 6'h00, OP_ORI = 6'h05, OP_LD = 6'h10,
                           OP_ST = 6'h11, OP_BEQ = 6'h02;
    localparam logic [5:0] FN_ADD = 6'h01, FN_SUB = 6'h02, FN_AND = 6'h03, FN_SLT = 6'h04;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pc_wr = 0, pc_src = 0, ir_wr = 0, a_wr = 0, b_wr = 0, alu_src_b = 0, ext_zero = 0;
    logic [2:0] alu_ctrl = 3'b000;
    logic r_wr = 0, m_wr = 0, mem_wr = 0, reg_wr = 0, reg_dst = 0, mem_to_reg = 0;
    logic [5:0] opcode_o, funct_o;
    logic zero_o;
    logic [31:0] pc_o, alu_res_o, mdr_o;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    // Behavioural reference state.
    logic [31:0] m_pc, m_ir, m_a, m_b, m_r, m_m;
    logic [31:0] m_rf [32];
    logic [31:0] m_im [WORDS];
    logic [31:0] m_dm [WORDS];

    mc_datapath u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] ref_alu(input logic [2:0] f, input logic [31:0] x, input logic [31:0] y);
        case (f)
            3'b000: return x & y;
            3'b001: return x | y;
            3'b010: return x + y;
            3'b110: return x - y;
            3'b111: return (signed'(x) < signed'(y)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] sx16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] ref_opb();
        if (!alu_src_b) return m_b;
        return ext_zero ? {16'd0, m_ir[15:0]} : sx16(m_ir[15:0]);
    endfunction

    // Reference model: advances on each rising edge from the driven controls.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc <= 0; m_ir <= 0; m_a <= 0; m_b <= 0; m_r <= 0; m_m <= 0;
            for (int i = 0; i < 32; i++) m_rf[i] <= 0;
        end else begin
            if (pc_wr) m_pc <= pc_src ? m_pc + 4 + (sx16(m_ir[15:0]) << 2) : m_pc + 4;
            if (ir_wr) m_ir <= m_im[m_pc[7:2]];
            if (a_wr)  m_a  <= m_rf[m_ir[25:21]];
            if (b_wr)  m_b  <= m_rf[m_ir[20:16]];
            if (r_wr)  m_r  <= ref_alu(alu_ctrl, m_a, ref_opb());
            if (m_wr)  m_m  <= m_dm[m_r[7:2]];
            if (mem_wr) m_dm[m_r[7:2]] <= m_b;
            if (reg_wr) begin
                if ((reg_dst ? m_ir[15:11] : m_ir[20:16]) != 5'd0)
                    m_rf[reg_dst ? m_ir[15:11] : m_ir[20:16]] <= mem_to_reg ? m_m : m_r;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // Compare every output with the model.
    task automatic compare(input string req);
        chk(req, "pc", pc_o, m_pc);
        chk(req, "alu_res", alu_res_o, m_r);
        chk(req, "mdr", mdr_o, m_m);
        chk("R2", "opcode", {26'd0, opcode_o}, {26'd0, m_ir[31:26]});
        chk("R2", "funct", {26'd0, funct_o}, {26'd0, m_ir[5:0]});
        chk("R7", "zero", {31'd0, zero_o}, {31'd0, ref_alu(alu_ctrl, m_a, ref_opb()) == 32'd0});
    endtask

    task automatic clear_ctl();
        pc_wr = 0; pc_src = 0; ir_wr = 0; a_wr = 0; b_wr = 0; alu_src_b = 0; ext_zero = 0;
        alu_ctrl = 3'b000; r_wr = 0; m_wr = 0; mem_wr = 0; reg_wr = 0; reg_dst = 0; mem_to_reg = 0;
    endtask

    task automatic tick(input string req);
        @(posedge clk); @(negedge clk);
        compare(req);
        clear_ctl();
    endtask

    task automatic fetch_decode();
        ir_wr = 1; tick("R3");
        a_wr = 1; b_wr = 1; tick("R4");
    endtask

    task automatic do_rtype(input logic [2:0] f);
        fetch_decode();
        alu_ctrl = f; r_wr = 1; tick("R5");
        reg_wr = 1; reg_dst = 1; pc_wr = 1; tick("R9");
    endtask

    task automatic do_ori();
        fetch_decode();
        alu_src_b = 1; ext_zero = 1; alu_ctrl = 3'b001; r_wr = 1; tick("R6");
        reg_wr = 1; pc_wr = 1; tick("R9");
    endtask

    task automatic do_load();
        fetch_decode();
        alu_src_b = 1; alu_ctrl = 3'b010; r_wr = 1; tick("R6");
        m_wr = 1; tick("R11");
        reg_wr = 1; mem_to_reg = 1; pc_wr = 1; tick("R9");
    endtask

    task automatic do_store();
        fetch_decode();
        alu_src_b = 1; alu_ctrl = 3'b010; r_wr = 1; tick("R6");
        mem_wr = 1; pc_wr = 1; tick("R11");
    endtask

    task automatic do_branch();
        fetch_decode();
        alu_ctrl = 3'b110; pc_wr = 1;
        #1 pc_src = zero_o;
        tick("R8");
    endtask

    function automatic logic [31:0] enc_r(input logic [4:0] s, input logic [4:0] t, input logic [4:0] d, input logic [5:0] fn);
        return {OP_RT, s, t, d, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] s, input logic [4:0] t, input logic [15:0] im);
        return {op, s, t, im};
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] prog [16];
        prog[0]  = enc_i(OP_ORI, 5'd0, 5'd1, 16'h8001);
        prog[1]  = enc_i(OP_LD,  5'd0, 5'd3, 16'h0008);
        prog[2]  = enc_r(5'd1, 5'd3, 5'd4, FN_ADD);
        prog[3]  = enc_r(5'd3, 5'd1, 5'd5, FN_SUB);
        prog[4]  = enc_r(5'd3, 5'd1, 5'd6, FN_SLT);
        prog[5]  = enc_r(5'd1, 5'd3, 5'd7, FN_AND);
        prog[6]  = enc_i(OP_ST,  5'd0, 5'd4, 16'h000C);
        prog[7]  = enc_i(OP_LD,  5'd0, 5'd9, 16'h000C);
        prog[8]  = enc_i(OP_BEQ, 5'd4, 5'd9, 16'h0002);
        prog[9]  = 32'hFFFF_FFFF;
        prog[10] = 32'hFFFF_FFFF;
        prog[11] = enc_i(OP_BEQ, 5'd1, 5'd3, 16'h0005);
        prog[12] = enc_i(OP_ORI, 5'd0, 5'd0, 16'h1234);
        prog[13] = enc_r(5'd0, 5'd1, 5'd11, FN_ADD);
        prog[14] = enc_i(OP_ORI, 5'd0, 5'd8, 16'h0010);
        prog[15] = enc_i(OP_LD,  5'd8, 5'd12, 16'hFFF8);
        for (int i = 0; i < WORDS; i++) begin
            logic [31:0] w;
            w = (i < 16) ? prog[i] : 32'd0;
            m_im[i] = w; u0.u_imem.mem[i] = w;
            w = (i == 2) ? 32'hFFFF_FFF0 : 32'hA500_0000 + i;
            m_dm[i] = w; u0.u_dmem.mem[i] = w;
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state after reset
        chk("R1", "pc", pc_o, 32'd0);
        chk("R1", "alu_res", alu_res_o, 32'd0);
        chk("R1", "mdr", mdr_o, 32'd0);
        rst_n = 1;

        tick("R3");                                   // idle cycle: all hold
        chk("R8", "pc hold", pc_o, 32'd0);

        ir_wr = 1; tick("R3");
        chk("R2", "ori opcode", {26'd0, opcode_o}, {26'd0, OP_ORI});
        a_wr = 1; b_wr = 1; tick("R4");
        alu_src_b = 1; ext_zero = 1; alu_ctrl = 3'b001; r_wr = 1; tick("R6");
        chk("R6", "zero-extended ori", alu_res_o, 32'h0000_8001);
        reg_wr = 1; pc_wr = 1; tick("R9");
        chk("R8", "pc+4", pc_o, 32'd4);

        do_load();
        chk("R11", "load word 2", mdr_o, 32'hFFFF_FFF0);
        do_rtype(3'b010); chk("R5", "add", alu_res_o, 32'h0000_7FF1);
        chk("R2", "funct add", {26'd0, funct_o}, {26'd0, FN_ADD});
        do_rtype(3'b110); chk("R5", "sub", alu_res_o, 32'hFFFF_7FEF);
        do_rtype(3'b111); chk("R5", "slt signed", alu_res_o, 32'd1);
        do_rtype(3'b000); chk("R5", "and", alu_res_o, 32'h0000_8000);
        do_store();
        do_load();
        chk("R11", "store then load", mdr_o, 32'h0000_7FF1);
        chk("R9", "loaded reg via pc", pc_o, 32'd32);
        do_branch();
        chk("R8", "taken branch", pc_o, 32'd44);
        do_branch();
        chk("R8", "untaken branch", pc_o, 32'd48);
        do_ori();
        do_rtype(3'b010);
        chk("R10", "r0 after write", alu_res_o, 32'h0000_8001);
        do_ori();
        do_load();
        chk("R6", "sign-extended offset", alu_res_o, 32'd8);
        chk("R11", "negative offset load", mdr_o, 32'hFFFF_FFF0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule